// File: doc/BRIEF.md
# Oscillator Temperature Compensation Scheduler

This block decides when a temperature measurement is taken for a temperature-compensated crystal oscillator. It also keeps the crystal load-capacitance trim code current. It starts a conversion on its own just after reset, then one on every sixty-fourth pulse of a one-second tick. Software can also ask for a conversion through a request bit. Each conversion is a simple start/done handshake with an external sensor, which returns a 10-bit signed reading.

Each finished conversion updates the temperature bytes. The trim code is the external base capacitance code plus a signed 8-bit aging offset, clamped to the range of the trim code. It is rewritten at three points: after the first conversion following reset, after every manual conversion, and after a periodic conversion whose reading differs from the stored one. Software writes the aging offset at any time. The offset reaches the trim code only at the next conversion that recomputes it, so a manual conversion right after the write applies it at once.

Top module: `tcomp_ctrl`

## Requirements
- R1: While reset is held, temp_hi, temp_lo, aging_q, trim_code, busy and req_bit are all zero.
- R2: After reset is released, a conversion starts without any tick or request, within two cycles. Its completion always rewrites trim_code, even when the reading equals the reset value of zero.
- R3: With no other activity, a periodic conversion starts on the 64th sec_tick pulse after reset, or after the previous period boundary, and on no earlier pulse. Manual conversions do not restart this count.
- R4: A one-cycle pulse on req_set starts a conversion. req_bit reads 1 from the cycle after the pulse until the conversion finishes, then returns to 0.
- R5: A req_set pulse that arrives while busy is high is held. req_bit stays 1, and a new conversion starts right after the current one ends.
- R6: A req_set pulse and a 64th tick in the same cycle produce one conversion only. It is treated as manual, so trim_code is recomputed.
- R7: When a conversion ends with result r (10-bit two's complement, 0.25 degree per step), temp_hi becomes r[9:2] and temp_lo becomes {r[1:0], 6'b000000}.
- R8: A periodic conversion whose reading equals the stored reading leaves trim_code unchanged. One with a different reading loads trim_code from the current base_cap and aging_q.
- R9: A write to aging_q updates the read-back value on the next cycle. It leaves trim_code unchanged and starts no conversion.
- R10: A recomputed trim_code equals base_cap plus aging_q read as a signed value in -128..127. The sum is clamped to 0 when negative and to 2^CAP_W-1 when above that limit.
- R11: A sense_done pulse while no conversion is running changes neither the temperature bytes nor trim_code.
- R12: sense_start is a single-cycle pulse. busy is high from the following cycle until the cycle in which sense_done is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| req_set | input | 1 | Software writes 1 to the conversion request bit |
| aging_we | input | 1 | Write strobe for the aging offset |
| aging_wdata | input | 8 | New aging offset, two's complement |
| sense_start | output | 1 | Conversion start pulse to the sensor |
| sense_done | input | 1 | Sensor reports the end of a conversion |
| sense_result | input | 10 | Sensor reading, valid with sense_done |
| base_cap | input | CAP_W | Base capacitance code from the compensation table |
| temp_hi | output | 8 | Integer temperature byte, read-only |
| temp_lo | output | 8 | Fraction in bits 7:6, other bits zero |
| aging_q | output | 8 | Aging offset read-back |
| trim_code | output | CAP_W | Capacitance trim code to the oscillator |
| busy | output | 1 | A conversion is in progress |
| req_bit | output | 1 | Request bit read-back |

## Verification
The bench goes after the points where the rewrite rule can go wrong. One is a periodic conversion that returns an unchanged reading; a design that always rewrites would then pick up a changed base code. Another is the first conversion after reset returning zero; a design that only compares readings would leave the trim code at zero. A request and a period boundary on the same cycle must give exactly one conversion that recomputes the trim code, and a request arriving during a conversion must not be lost. The bench also sweeps all 1024 readings through the temperature bytes, and all 256 offsets against base codes at both ends of the range. These sweeps catch a lost sign extension or a wrap where the sum should clamp.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;

  localparam int unsigned TEMP_W = 10;
  localparam int unsigned OFF_W  = 8;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;

  // Base code plus signed offset, clamped to [0, 2^cap_w - 1].
  function automatic int sat_trim(input int base, input logic [OFF_W-1:0] off,
                                  input int cap_w);
    int sum;
    int lim;
    lim = (1 << cap_w) - 1;
    sum = base + int'($signed(off));
    if (sum < 0)        return 0;
    else if (sum > lim) return lim;
    else                return sum;
  endfunction

  function automatic logic [7:0] temp_int_byte(input logic [TEMP_W-1:0] r);
    return r[TEMP_W-1:2];
  endfunction

  function automatic logic [7:0] temp_frac_byte(input logic [TEMP_W-1:0] r);
    return {r[1:0], 6'b000000};
  endfunction

endpackage

// File: rtl/tcomp_cadence.sv
module tcomp_cadence #(
  parameter int unsigned PERIOD_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  output logic period_evt
);
  localparam int unsigned CNT_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic             at_last;

  assign at_last    = (tick_cnt == LAST);
  assign period_evt = sec_tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (sec_tick) begin
      tick_cnt <= at_last ? '0 : tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tcomp_seq.sv
module tcomp_seq
  import tcomp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic period_evt,
  input  logic req_set,
  input  logic sense_done,
  output logic sense_start,
  output logic busy,
  output logic req_bit,
  output logic conv_finish,
  output logic finish_forced
);
  seq_state_e state;
  logic por_pend;
  logic man_pend;
  logic per_pend;
  logic cur_forced;
  logic launch;

  assign launch        = (state == SEQ_IDLE) && (por_pend || man_pend || per_pend);
  assign conv_finish   = (state == SEQ_CONV) && sense_done;
  assign sense_start   = launch;
  assign busy          = (state == SEQ_CONV);
  assign req_bit       = man_pend || busy;
  assign finish_forced = cur_forced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      por_pend   <= 1'b1;
      man_pend   <= 1'b0;
      per_pend   <= 1'b0;
      cur_forced <= 1'b0;
    end else begin
      if (launch) begin
        // Every pending cause is merged into this one conversion.
        state      <= SEQ_CONV;
        cur_forced <= por_pend || man_pend;
        por_pend   <= 1'b0;
        man_pend   <= req_set;
        per_pend   <= period_evt;
      end else begin
        man_pend <= man_pend || req_set;
        per_pend <= per_pend || period_evt;
        if (conv_finish) state <= SEQ_IDLE;
      end
    end
  end
endmodule

// File: rtl/tcomp_trim.sv
module tcomp_trim
  import tcomp_pkg::*;
#(
  parameter int unsigned CAP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_finish,
  input  logic              finish_forced,
  input  logic [TEMP_W-1:0] sense_result,
  input  logic              aging_we,
  input  logic [OFF_W-1:0]  aging_wdata,
  input  logic [CAP_W-1:0]  base_cap,
  output logic [7:0]        temp_hi,
  output logic [7:0]        temp_lo,
  output logic [OFF_W-1:0]  aging_q,
  output logic [CAP_W-1:0]  trim_code,
  output logic              trim_load
);
  logic [TEMP_W-1:0] temp_raw;
  logic              temp_changed;
  logic [CAP_W-1:0]  trim_next;

  assign temp_changed = (sense_result != temp_raw);
  assign trim_load    = conv_finish && (finish_forced || temp_changed);
  assign trim_next    = CAP_W'(sat_trim(int'(base_cap), aging_q, int'(CAP_W)));
  assign temp_hi      = temp_int_byte(temp_raw);
  assign temp_lo      = temp_frac_byte(temp_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_raw <= '0;
    end else if (conv_finish) begin
      temp_raw <= sense_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aging_q <= '0;
    end else if (aging_we) begin
      aging_q <= aging_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_code <= '0;
    end else if (trim_load) begin
      trim_code <= trim_next;
    end
  end
endmodule

// File: rtl/tcomp_ctrl.sv
module tcomp_ctrl
  import tcomp_pkg::*;
#(
  parameter int unsigned CAP_W        = 8,
  parameter int unsigned PERIOD_TICKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             req_set,
  input  logic             aging_we,
  input  logic [7:0]       aging_wdata,
  output logic             sense_start,
  input  logic             sense_done,
  input  logic [9:0]       sense_result,
  input  logic [CAP_W-1:0] base_cap,
  output logic [7:0]       temp_hi,
  output logic [7:0]       temp_lo,
  output logic [7:0]       aging_q,
  output logic [CAP_W-1:0] trim_code,
  output logic             busy,
  output logic             req_bit
);
  // Internal events, named for the checker.
  logic period_evt;
  logic conv_finish;
  logic finish_forced;
  logic trim_load;

  tcomp_cadence #(.PERIOD_TICKS(PERIOD_TICKS)) u_cadence (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .period_evt (period_evt)
  );

  tcomp_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_evt    (period_evt),
    .req_set       (req_set),
    .sense_done    (sense_done),
    .sense_start   (sense_start),
    .busy          (busy),
    .req_bit       (req_bit),
    .conv_finish   (conv_finish),
    .finish_forced (finish_forced)
  );

  tcomp_trim #(.CAP_W(CAP_W)) u_trim (
    .clk           (clk),
    .rst_n         (rst_n),
    .conv_finish   (conv_finish),
    .finish_forced (finish_forced),
    .sense_result  (sense_result),
    .aging_we      (aging_we),
    .aging_wdata   (aging_wdata),
    .base_cap      (base_cap),
    .temp_hi       (temp_hi),
    .temp_lo       (temp_lo),
    .aging_q       (aging_q),
    .trim_code     (trim_code),
    .trim_load     (trim_load)
  );
endmodule

// File: rtl/tcomp_ctrl_chk.sv
module tcomp_ctrl_chk #(
  parameter int unsigned CAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sense_start,
  input logic             busy,
  input logic             req_bit,
  input logic             conv_finish,
  input logic             trim_load,
  input logic [7:0]       temp_hi,
  input logic [7:0]       temp_lo,
  input logic [CAP_W-1:0] trim_code
);
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sense_start |=> !sense_start);

  a_r12_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    sense_start |=> busy);

  a_r6_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sense_start);

  a_r4_req_reads_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> req_bit);

  a_r11_temp_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(temp_hi) && $stable(temp_lo)));

  a_r9_trim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_load |=> $stable(trim_code));

  a_r8_load_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    trim_load |-> (conv_finish && busy));
endmodule

bind tcomp_ctrl tcomp_ctrl_chk #(.CAP_W(CAP_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sense_start (sense_start),
  .busy        (busy),
  .req_bit     (req_bit),
  .conv_finish (conv_finish),
  .trim_load   (trim_load),
  .temp_hi     (temp_hi),
  .temp_lo     (temp_lo),
  .trim_code   (trim_code)
);

// File: tb/test_tcomp_ctrl.sv
module test_tcomp_ctrl;
  localparam int CAP_W = 8;
  localparam int LIM   = (1 << CAP_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sec_tick = 1'b0;
  logic             req_set = 1'b0;
  logic             aging_we = 1'b0;
  logic [7:0]       aging_wdata = '0;
  logic             sense_start;
  logic             sense_done = 1'b0;
  logic [9:0]       sense_result = '0;
  logic [CAP_W-1:0] base_cap = '0;
  logic [7:0]       temp_hi, temp_lo, aging_q;
  logic [CAP_W-1:0] trim_code;
  logic             busy, req_bit;

  int n_vec = 0;
  int n_bad = 0;
  bit all_done = 1'b0;

  always #4 clk = ~clk;

  tcomp_ctrl #(.CAP_W(CAP_W), .PERIOD_TICKS(64)) i_tcomp_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expect_trim(input int base, input int off8);
    int s;
    s = base + ((off8 >= 128) ? off8 - 256 : off8);
    if (s < 0) s = 0;
    if (s > LIM) s = LIM;
    return s;
  endfunction

  // All tasks start and end just after a falling edge.
  task automatic wait_start(input string tag, input int max_wait);
    int n = 0;
    while (!sense_start && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " start seen"}, int'(sense_start), 1);
    chk({tag, " start delay ok"}, int'(n <= max_wait), 1);
  endtask

  task automatic finish_conv(input logic [9:0] t);
    @(negedge clk);
    sense_done   = 1'b1;
    sense_result = t;
    @(negedge clk);
    sense_done = 1'b0;
  endtask

  task automatic pulse_req();
    req_set = 1'b1;
    @(negedge clk);
    req_set = 1'b0;
  endtask

  task automatic write_aging(input logic [7:0] v);
    aging_we    = 1'b1;
    aging_wdata = v;
    @(negedge clk);
    aging_we = 1'b0;
  endtask

  task automatic tick_n(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      if (i < n - 1) chk({tag, " no early start"}, int'(sense_start), 0);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({tag, " no start"}, int'(sense_start), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    base_cap = 8'd100;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 temp_hi", temp_hi, 0);
    chk("R1 temp_lo", temp_lo, 0);
    chk("R1 aging", aging_q, 0);
    chk("R1 trim", trim_code, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req_bit", req_bit, 0);

    // R2 power-up conversion, forced rewrite with reading of zero
    rst_n = 1'b1;
    wait_start("R2", 2);
    @(negedge clk);
    chk("R12 start single cycle", sense_start, 0);
    chk("R12 busy after start", busy, 1);
    sense_done = 1'b1; sense_result = 10'd0;
    @(negedge clk);
    sense_done = 1'b0;
    chk("R12 busy cleared", busy, 0);
    chk("R2 trim forced", trim_code, 100);

    // R9 aging write alone
    write_aging(8'd5);
    chk("R9 aging readback", aging_q, 5);
    chk("R9 trim unchanged", trim_code, 100);
    quiet(5, "R9");

    // R4 manual request, R7 format
    pulse_req();
    chk("R4 req_bit set", req_bit, 1);
    wait_start("R4", 1);
    @(negedge clk);
    chk("R4 req_bit while busy", req_bit, 1);
    sense_done = 1'b1; sense_result = 10'h064;
    @(negedge clk);
    sense_done = 1'b0;
    chk("R4 req_bit cleared", req_bit, 0);
    chk("R4 trim manual", trim_code, 105);
    chk("R7 temp_hi", temp_hi, 25);
    chk("R7 temp_lo", temp_lo, 0);

    // R5 request held while busy
    pulse_req();
    wait_start("R5 first", 1);
    @(negedge clk);
    pulse_req();
    sense_done = 1'b1; sense_result = 10'h064;
    @(negedge clk);
    sense_done = 1'b0;
    chk("R5 req_bit held", req_bit, 1);
    wait_start("R5 second", 1);
    finish_conv(10'h064);
    chk("R5 req_bit cleared", req_bit, 0);
    quiet(3, "R5");

    // R11 stray done while idle
    sense_done = 1'b1; sense_result = 10'h3FF;
    @(negedge clk);
    sense_done = 1'b0;
    @(negedge clk);
    chk("R11 temp_hi", temp_hi, 25);
    chk("R11 temp_lo", temp_lo, 0);
    chk("R11 trim", trim_code, 105);
    chk("R11 busy", busy, 0);

    // R3 / R8 periodic with unchanged reading
    base_cap = 8'd110;
    tick_n(63, "R3 first period");
    quiet(3, "R3 first period");
    tick_n(1, "R3");
    wait_start("R3 periodic", 0);
    finish_conv(10'h064);
    chk("R8 same reading keeps trim", trim_code, 105);

    // R3 count survives a manual conversion; R8 changed reading
    tick_n(30, "R3 second period");
    pulse_req();
    wait_start("R3 manual mid", 1);
    finish_conv(10'h064);
    chk("R3 manual mid trim", trim_code, 115);
    base_cap = 8'd120;
    tick_n(33, "R3 second period rest");
    chk("R3 not yet", sense_start, 0);
    tick_n(1, "R3");
    wait_start("R3 second periodic", 0);
    finish_conv(10'h065);
    chk("R8 changed reading loads", trim_code, 125);
    chk("R7 temp_lo frac", temp_lo, 64);

    // R6 request and boundary together
    base_cap = 8'd130;
    tick_n(63, "R6 approach");
    sec_tick = 1'b1; req_set = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; req_set = 1'b0;
    wait_start("R6", 1);
    finish_conv(10'h065);
    chk("R6 treated as manual", trim_code, 135);
    chk("R6 req_bit cleared", req_bit, 0);
    quiet(10, "R6 single conversion");

    // R7 sweep over all readings
    base_cap = 8'd50;
    write_aging(8'd0);
    for (int t = 0; t < 1024; t++) begin
      pulse_req();
      wait_start("R7 sweep", 1);
      finish_conv(10'(t));
      chk("R7 sweep temp_hi", temp_hi, (t >> 2) & 8'hFF);
      chk("R7 sweep temp_lo", temp_lo, (t & 3) << 6);
      chk("R7 sweep trim", trim_code, 50);
    end

    // R10 offset and clamp sweep
    for (int b = 0; b < 7; b++) begin
      int bv;
      case (b)
        0: bv = 0;   1: bv = 1;   2: bv = 100; 3: bv = 127;
        4: bv = 128; 5: bv = 254; default: bv = 255;
      endcase
      base_cap = 8'(bv);
      for (int a = 0; a < 256; a++) begin
        write_aging(8'(a));
        pulse_req();
        wait_start("R10 sweep", 1);
        finish_conv(10'd0);
        chk("R10 trim", trim_code, expect_trim(bv, a));
      end
    end

    all_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule